// File: doc/BRIEF.md
# Write Progress Status Generator

This block forms the byte a host sees on a read while a write is being loaded or committed to the array. During those phases it replaces array data with a status byte. The byte carries five things: a polling bit derived from the most recent byte written, a toggle bit that inverts on each read, a flag for the commit phase, a sticky flag for an abandoned page load, and the current write-protection state.

A page write controller drives the block with phase pulses. A write strobe opens or extends the load window, a go pulse marks the start of the internal write, a done pulse marks its end, and an abort pulse marks a load that was abandoned because its bytes fell on more than one page. A separate pair of pulses enters and leaves a query mode. The controller raises these after it has decoded the protection-read unlock writes, and the host reads the protection bit in that mode. When no phase is active, the read path passes array data through unchanged.

The controller is one state machine with four states. `S_IDLE` is normal array read. `S_LOAD` is the load window. `S_BUSY` is the internal write. `S_QUERY` is the protection read. The transitions are:
- open_load: `S_IDLE` to `S_LOAD` on a write strobe.
- enter_query: `S_IDLE` to `S_QUERY`.
- start_commit: `S_LOAD` to `S_BUSY` on go.
- abandon: `S_LOAD` to `S_IDLE` on abort.
- finish: `S_BUSY` to `S_IDLE` on done.
- leave_query: `S_QUERY` to `S_IDLE`.

Top module: `wr_status_gen`

## Requirements
- R1: After reset the block is in `S_IDLE`. `stat_mode` is 0 and `rd_data` equals `arr_data`. The toggle bit, the captured polling reference and the abort flag are all 0.
- R2: A `byte_wr` pulse in `S_IDLE` moves the block to `S_LOAD` on the next cycle. In `S_LOAD`, `stat_mode` is 1 and `rd_data` is the status byte, in which bit 5 is 0.
- R3: The polling reference is bit 7 of `wr_byte`. It is captured on every `byte_wr` in `S_IDLE` or `S_LOAD`. A `byte_wr` in `S_BUSY` or `S_QUERY` leaves it unchanged.
- R4: `write_go` in `S_LOAD` moves the block to `S_BUSY` on the next cycle. Status bit 5 is 1 throughout `S_BUSY`.
- R5: Status bit 6 is the toggle bit. It inverts on the clock edge that ends a cycle with `rd_stb` high in `S_BUSY`. In every other case it holds, including reads in other states.
- R6: `write_done` in `S_BUSY` moves the block to `S_IDLE` on the next cycle, and from then on `rd_data` equals `arr_data`. A read in the done cycle still sees the busy status byte, and it still inverts the toggle bit.
- R7: `write_abort` in `S_LOAD` returns the block to `S_IDLE` and sets the abort flag, which reads as status bit 1. Abort takes priority over a simultaneous `write_go`. The flag is cleared by the `byte_wr` that opens the next load.
- R8: `qry_enter` in `S_IDLE` moves the block to `S_QUERY`, and `qry_leave` returns it to `S_IDLE`. In `S_QUERY`, status bit 0 follows `prot_on` combinationally and bit 5 is 0.
- R9: Status bit 7 is the inverted polling reference in `S_LOAD` and `S_BUSY`, and the true polling reference in `S_QUERY`.
- R10: Status bits 4 to 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One read access this cycle |
| byte_wr | input | 1 | Host byte write this cycle |
| wr_byte | input | DW | Data of that byte write |
| write_go | input | 1 | Load window closed, internal write starts |
| write_done | input | 1 | Internal write finished |
| write_abort | input | 1 | Page load abandoned (cross-page) |
| qry_enter | input | 1 | Enter protection query mode |
| qry_leave | input | 1 | Leave protection query mode |
| prot_on | input | 1 | Current write-protection state |
| arr_data | input | DW | Array read data |
| rd_data | output | DW | Byte presented to the host |
| stat_mode | output | 1 | 1 when `rd_data` is the status byte |

## Verification
Two pairs of events can coincide. The first pair is a read and the end of the internal write. The bench raises `rd_stb` and `write_done` in the same cycle. It expects the busy byte in that cycle, array data on the next cycle, and an inverted toggle bit when the status is read again later in query mode. The second pair is an abort and a go in the same load cycle. The bench expects the abort to win: the block returns to array data instead of entering the busy phase, and the abort flag reads back as 1 through query mode.

// File: rtl/wps_pkg.sv
package wps_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOAD  = 2'd1,
        S_BUSY  = 2'd2,
        S_QUERY = 2'd3
    } wps_state_t;

    localparam int BIT_POLL   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_COMMIT = 5;
    localparam int BIT_ABORT  = 1;
    localparam int BIT_PROT   = 0;
endpackage

// File: rtl/wps_fsm.sv
module wps_fsm
    import wps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_wr,
    input  logic       write_go,
    input  logic       write_done,
    input  logic       write_abort,
    input  logic       qry_enter,
    input  logic       qry_leave,
    output wps_state_t state,
    output logic       new_load,
    output logic       cap_en,
    output logic       abort_set
);
    wps_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (byte_wr)        st_d = S_LOAD;
                else if (qry_enter) st_d = S_QUERY;
            end
            S_LOAD: begin
                if (write_abort)    st_d = S_IDLE;
                else if (write_go)  st_d = S_BUSY;
            end
            S_BUSY: begin
                if (write_done)     st_d = S_IDLE;
            end
            S_QUERY: begin
                if (qry_leave)      st_d = S_IDLE;
            end
            default:                st_d = S_IDLE;
        endcase
    end

    always_comb begin
        new_load  = 1'b0;
        cap_en    = 1'b0;
        abort_set = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                new_load = byte_wr;
                cap_en   = byte_wr;
            end
            S_LOAD: begin
                cap_en    = byte_wr;
                abort_set = write_abort;
            end
            default: ;
        endcase
    end

    assign state = st_q;

    assert_open_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && byte_wr) |=> (st_q == S_LOAD));
    assert_start_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LOAD && write_go && !write_abort) |=> (st_q == S_BUSY));
    assert_abort_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LOAD && write_abort) |=> (st_q == S_IDLE));
    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BUSY && write_done) |=> (st_q == S_IDLE));
    assert_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !byte_wr && qry_enter) |=> (st_q == S_QUERY));
endmodule

// File: rtl/wps_toggle.sv
module wps_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic tog
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tog <= 1'b0;
        else if (flip) tog <= ~tog;
    end

    assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (tog != $past(tog)));
    assert_toggle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !flip |=> $stable(tog));
endmodule

// File: rtl/wps_flags.sv
module wps_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] wr_byte,
    input  logic          new_load,
    input  logic          abort_set,
    output logic          poll_ref,
    output logic          abort_flag
);
    localparam int MSB = DW - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      poll_ref <= 1'b0;
        else if (cap_en) poll_ref <= wr_byte[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         abort_flag <= 1'b0;
        else if (abort_set) abort_flag <= 1'b1;
        else if (new_load)  abort_flag <= 1'b0;
    end

    assert_abort_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && !new_load) |=> abort_flag);
    assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(poll_ref));
endmodule

// File: rtl/wr_status_gen.sv
module wr_status_gen
    import wps_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          byte_wr,
    input  logic [DW-1:0] wr_byte,
    input  logic          write_go,
    input  logic          write_done,
    input  logic          write_abort,
    input  logic          qry_enter,
    input  logic          qry_leave,
    input  logic          prot_on,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] rd_data,
    output logic          stat_mode
);
    wps_state_t state;
    logic new_load, cap_en, abort_set;
    logic tog, poll_ref, abort_flag;
    logic [DW-1:0] status;

    wps_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .write_go(write_go),
        .write_done(write_done), .write_abort(write_abort),
        .qry_enter(qry_enter), .qry_leave(qry_leave), .state(state),
        .new_load(new_load), .cap_en(cap_en), .abort_set(abort_set)
    );

    wps_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .flip(rd_stb && state == S_BUSY), .tog(tog)
    );

    wps_flags #(.DW(DW)) u_flags (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .wr_byte(wr_byte),
        .new_load(new_load), .abort_set(abort_set),
        .poll_ref(poll_ref), .abort_flag(abort_flag)
    );

    always_comb begin
        status             = '0;
        status[BIT_TOGGLE] = tog;
        status[BIT_ABORT]  = abort_flag;
        status[BIT_PROT]   = prot_on;
        unique case (state)
            S_LOAD: status[BIT_POLL] = ~poll_ref;
            S_BUSY: begin
                status[BIT_POLL]   = ~poll_ref;
                status[BIT_COMMIT] = 1'b1;
            end
            default: status[BIT_POLL] = poll_ref;
        endcase
    end

    always_comb begin
        stat_mode = (state != S_IDLE);
        rd_data   = stat_mode ? status : arr_data;
    end

    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode |-> (rd_data[4:2] == 3'b000));
    assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_mode |-> (rd_data == arr_data));
endmodule

// File: tb/sim_wr_status_gen.sv
module sim_wr_status_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_stb = 0, byte_wr = 0, write_go = 0, write_done = 0, write_abort = 0;
    logic qry_enter = 0, qry_leave = 0, prot_on = 0;
    logic [7:0] wr_byte = 8'h00, arr_data = 8'h5A;
    logic [7:0] rd_data;
    logic stat_mode;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    wr_status_gen u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .byte_wr(byte_wr),
        .wr_byte(wr_byte), .write_go(write_go), .write_done(write_done),
        .write_abort(write_abort), .qry_enter(qry_enter), .qry_leave(qry_leave),
        .prot_on(prot_on), .arr_data(arr_data), .rd_data(rd_data), .stat_mode(stat_mode)
    );

    task automatic check(input string req, input logic m, input logic [7:0] d);
        #1;
        total++;
        if (stat_mode !== m || rd_data !== d) begin
            bad++;
            $display("FAIL %s: mode=%b data=%h expected mode=%b data=%h",
                     req, stat_mode, rd_data, m, d);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #4;
        rd_stb = 0; byte_wr = 0; write_go = 0; write_done = 0;
        write_abort = 0; qry_enter = 0; qry_leave = 0;
    endtask

    task automatic t_reset;
        check("R1 reset passthrough", 1'b0, 8'h5A);
    endtask

    task automatic t_load;
        prot_on = 1;
        byte_wr = 1; wr_byte = 8'h80; tick();
        check("R2 load status", 1'b1, 8'h01);
        byte_wr = 1; wr_byte = 8'h00; tick();
        check("R3 recapture in load", 1'b1, 8'h81);
    endtask

    task automatic t_busy;
        write_go = 1; tick();
        check("R4 commit bit", 1'b1, 8'hA1);
        rd_stb = 1;
        check("R5 read sees old toggle", 1'b1, 8'hA1);
        tick();
        check("R5 toggle inverted", 1'b1, 8'hE1);
        tick();
        check("R5 toggle holds without read", 1'b1, 8'hE1);
        rd_stb = 1; tick();
        check("R5 toggle back", 1'b1, 8'hA1);
        byte_wr = 1; wr_byte = 8'hFF; tick();
        check("R3 write in busy ignored R9", 1'b1, 8'hA1);
    endtask

    task automatic t_done_read;
        rd_stb = 1; write_done = 1;
        check("R6 busy byte in done cycle", 1'b1, 8'hA1);
        tick();
        check("R6 passthrough after done", 1'b0, 8'h5A);
        qry_enter = 1; tick();
        check("R8 query status R9 true poll", 1'b1, 8'h41);
        prot_on = 0;
        check("R8 prot follows input", 1'b1, 8'h40);
        byte_wr = 1; wr_byte = 8'h80; tick();
        check("R3 write in query ignored", 1'b1, 8'h40);
        qry_leave = 1; tick();
        check("R8 leave query", 1'b0, 8'h5A);
    endtask

    task automatic t_abort;
        byte_wr = 1; wr_byte = 8'h00; tick();
        check("R2 second load", 1'b1, 8'hC0);
        write_abort = 1; write_go = 1; tick();
        check("R7 abort beats go", 1'b0, 8'h5A);
        qry_enter = 1; tick();
        check("R7 abort flag visible R10", 1'b1, 8'h42);
        qry_leave = 1; tick();
        byte_wr = 1; wr_byte = 8'h80; tick();
        check("R7 flag cleared by new load", 1'b1, 8'h40);
        rd_stb = 1; tick();
        check("R5 read in load no toggle", 1'b1, 8'h40);
        write_go = 1; tick();
        write_done = 1; tick();
        check("R6 idle after second write", 1'b0, 8'h5A);
    endtask

    initial begin
        #25;
        t_reset();
        rst_n = 1;
        #20;
        t_load();
        t_busy();
        t_done_read();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule